// File: doc/BRIEF.md
# Hybrid Carry-Select Lookahead Adder

This block is a purely combinational 64-bit binary adder with a carry input and a carry output. It is meant for datapaths that need a full-width add with a short critical path. The result settles within the same cycle the operands are applied, so the surrounding logic registers it wherever its timing allows.

The operands are cut into eight 8-bit slices. Each slice builds two candidate results side by side: one as if no carry entered it, and one as if a carry did. The carries at the slice boundaries never ripple from slice to slice. A prefix tree produces them instead. The tree is built from modules that each merge four neighbouring propagate/generate pairs and return three running prefixes. Its first level works on nibbles, its second on 8- and 16-bit spans, and its third uses overlapping spans to reach bits 23, 31, 39, 47 and 55. The incoming carry is merged into the generate term of bit 0. The final carry out comes from the top slice: the boundary carry into that slice picks one of the slice's two conditional carry-outs.

The block has no handshake of any kind. The operands are plain level inputs, and the outputs follow them combinationally.

Top module: `hca_adder64`

## Requirements
- R1: For any operands and carry input, {carry_o, sum_o} equals the 65-bit sum a_i + b_i + carry_i.
- R2: For each 8-bit slice, the candidate that assumes an incoming carry is the other candidate plus one, modulo 256. A slice whose two operand bytes sum to 0xFF and that receives a carry therefore yields 0x00.
- R3: A slice whose own operand bytes sum to 256 or more passes a carry to the slice above, whatever carry it receives itself.
- R4: For every boundary at bit 8k (k = 1..7), the carry entering slice k equals the carry out of the 8k-bit sum of the lower bits plus carry_i. It arrives even when every lower bit only propagates.
- R5: carry_i enters at bit 0. With b_i equal to the bitwise inverse of a_i, a carry input of 1 gives sum_o = 0 and carry_o = 1, and a carry input of 0 gives sum_o all ones and carry_o = 0.
- R6: With both operands all ones, the result is all ones except bit 0, with carry_o = 1. That bit 0 equals carry_i.
- R7: The outputs depend on the present inputs only. Two different operand sets applied within one clock period each give their own correct result, with no clock edge between them.
- R8: carry_o is correct both when the carry is generated inside the top slice (bit 63 of both operands set) and when a carry from bit 55 travels through an all-propagating top slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 64 | Sum bits |
| carry_o | output | 1 | Carry out of bit 63 |

## Verification
Zero operands and inverse operands with either carry input test how carry_i is merged at bit 0. They also test the longest path, where every bit propagates and the carry must cross the whole word. Patterns that fill the bits below each slice boundary with ones and then add one test each of the seven tree carries on its own. Patterns that make a single slice generate test the generate path, separate from the propagate path. Bit-63 and carry-through-the-top cases separate the two ways carry_o can arise, and random operands cover the mixed cases. Two operand sets applied within one clock period show that no state is kept.

// File: rtl/hca_pkg.sv
`timescale 1ns/1ps
package hca_pkg;

  // propagate/generate pair of a bit span
  typedef struct packed {
    logic p;
    logic g;
  } pg_t;

  // neutral element of the carry operator
  localparam pg_t PG_IDENT = '{p: 1'b1, g: 1'b0};

  // merge a more significant span (hi) onto a less significant one (lo)
  function automatic pg_t pg_join(input pg_t hi, input pg_t lo);
    pg_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction

endpackage

// File: rtl/hca_pg_gen.sv
`timescale 1ns/1ps
module hca_pg_gen #(
  parameter int W = 64
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] g_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign p_o[i] = a_i[i] ^ b_i[i];
    assign g_o[i] = a_i[i] & b_i[i];
  end

endmodule

// File: rtl/hca_combine4.sv
`timescale 1ns/1ps
module hca_combine4
  import hca_pkg::*;
(
  input  pg_t [3:0] span_i,   // index 0 is the least significant span
  output pg_t [2:0] cum_o     // prefixes over 2, 3 and 4 spans
);

  pg_t two_q, three_q, four_q;

  always_comb begin
    two_q   = pg_join(span_i[1], span_i[0]);
    three_q = pg_join(span_i[2], two_q);
    four_q  = pg_join(span_i[3], three_q);
  end

  assign cum_o = {four_q, three_q, two_q};

endmodule

// File: rtl/hca_carry_tree.sv
`timescale 1ns/1ps
module hca_carry_tree
  import hca_pkg::*;
#(
  parameter int GROUP_W  = 8,
  parameter int N_GROUPS = 8
) (
  input  logic [GROUP_W*(N_GROUPS-1)-1:0] p_i,
  input  logic [GROUP_W*(N_GROUPS-1)-1:0] g_i,
  input  logic                            carry_i,
  output logic [N_GROUPS-1:0]             gc_o     // carry into each slice
);

  localparam int SPAN = GROUP_W * (N_GROUPS - 1);
  localparam int NIB  = SPAN / 4;
  localparam int L2_N = (NIB + 3) / 4;
  localparam int NPG  = GROUP_W / 4;

  if (GROUP_W != 8 || N_GROUPS != 8) begin : g_bad_shape
    $error("hca_carry_tree: tree wiring supports 8 slices of 8 bits only");
  end

  // bit-level pairs with the external carry merged into bit 0
  pg_t [SPAN-1:0] bit_pg;
  always_comb begin
    for (int i = 0; i < SPAN; i++) begin
      bit_pg[i].p = p_i[i];
      bit_pg[i].g = g_i[i];
    end
    bit_pg[0].g = g_i[0] | (p_i[0] & carry_i);
  end

  // level 1: nibble spans 3:0 .. 55:52
  pg_t [2:0] l1_cum [NIB];
  pg_t       nib_pg [NIB];
  for (genvar n = 0; n < NIB; n++) begin : g_l1
    hca_combine4 u_c4 (
      .span_i (bit_pg[4*n+3:4*n]),
      .cum_o  (l1_cum[n])
    );
    assign nib_pg[n] = l1_cum[n][2];
  end

  // level 2: four modules over consecutive nibbles, padded with identity
  pg_t [3:0] l2_in  [L2_N];
  pg_t [2:0] l2_cum [L2_N];
  for (genvar m = 0; m < L2_N; m++) begin : g_l2
    for (genvar j = 0; j < 4; j++) begin : g_in
      if (4*m + j < NIB) begin : g_real
        assign l2_in[m][j] = nib_pg[4*m+j];
      end else begin : g_pad
        assign l2_in[m][j] = PG_IDENT;
      end
    end
    hca_combine4 u_c4 (
      .span_i (l2_in[m]),
      .cum_o  (l2_cum[m])
    );
  end

  pg_t s7_0, s15_0, s23_16, s31_16, s39_32, s47_32, s55_48;
  assign s7_0   = l2_cum[0][0];
  assign s15_0  = l2_cum[0][2];
  assign s23_16 = l2_cum[1][0];
  assign s31_16 = l2_cum[1][2];
  assign s39_32 = l2_cum[2][0];
  assign s47_32 = l2_cum[2][2];
  assign s55_48 = l2_cum[3][0];

  // level 3: overlapping spans reach 23, 31, 39 and 47, 55
  pg_t [3:0] l3_in  [2];
  pg_t [2:0] l3_cum [2];
  assign l3_in[0] = {s39_32, s31_16, s23_16, s15_0};
  assign l3_in[1] = {s55_48, s47_32, s31_16, s15_0};
  for (genvar t = 0; t < 2; t++) begin : g_l3
    hca_combine4 u_c4 (
      .span_i (l3_in[t]),
      .cum_o  (l3_cum[t])
    );
  end

  assign gc_o[0] = carry_i;
  assign gc_o[1] = s7_0.g;
  assign gc_o[2] = s15_0.g;
  assign gc_o[3] = l3_cum[0][0].g;
  assign gc_o[4] = l3_cum[0][1].g;
  assign gc_o[5] = l3_cum[0][2].g;
  assign gc_o[6] = l3_cum[1][1].g;
  assign gc_o[7] = l3_cum[1][2].g;

  // a wider prefix can only propagate if every narrower one does
  for (genvar n = 0; n < NIB; n++) begin : g_l1_chk
    always_comb begin
      AST_PREFIX_MONO: assert (!(l1_cum[n][2].p && !l1_cum[n][1].p) && !(l1_cum[n][1].p && !l1_cum[n][0].p))
        else $error("level-1 prefix propagate not monotonic"); // R4
    end
  end
  for (genvar m = 0; m < L2_N; m++) begin : g_l2_chk
    always_comb begin
      AST_PREFIX_MONO: assert (!(l2_cum[m][2].p && !l2_cum[m][1].p) && !(l2_cum[m][1].p && !l2_cum[m][0].p))
        else $error("level-2 prefix propagate not monotonic"); // R4
    end
  end
  for (genvar t = 0; t < 2; t++) begin : g_l3_chk
    always_comb begin
      AST_PREFIX_MONO: assert (!(l3_cum[t][2].p && !l3_cum[t][1].p) && !(l3_cum[t][1].p && !l3_cum[t][0].p))
        else $error("level-3 prefix propagate not monotonic"); // R4
    end
  end

  // slice-level propagate passes the carry on; slice-level generate forces it
  for (genvar k = 0; k < N_GROUPS-1; k++) begin : g_slice_chk
    pg_t slice_pg;
    assign slice_pg = pg_join(nib_pg[NPG*k+1], nib_pg[NPG*k]);
    always_comb begin
      AST_PROP_CHAIN: assert (!(gc_o[k] && slice_pg.p) || gc_o[k+1])
        else $error("carry lost across propagating slice"); // R4
      AST_GEN_CHAIN: assert (!slice_pg.g || gc_o[k+1])
        else $error("generating slice did not carry"); // R3
    end
  end

endmodule

// File: rtl/hca_group_sum.sv
`timescale 1ns/1ps
module hca_group_sum #(
  parameter int W = 8
) (
  input  logic [W-1:0] p_i,
  input  logic [W-1:0] g_i,
  input  logic         sel_i,    // carry into this slice
  output logic [W-1:0] sum_o,
  output logic         cout_o
);

  logic [W-1:0] s0, s1;
  logic         co0, co1;

  // two local ripple chains, one per assumed incoming carry
  always_comb begin
    logic c0, c1;
    c0 = 1'b0;
    c1 = 1'b1;
    for (int i = 0; i < W; i++) begin
      s0[i] = p_i[i] ^ c0;
      s1[i] = p_i[i] ^ c1;
      c0    = g_i[i] | (p_i[i] & c0);
      c1    = g_i[i] | (p_i[i] & c1);
    end
    co0 = c0;
    co1 = c1;
  end

  assign sum_o  = sel_i ? s1  : s0;
  assign cout_o = sel_i ? co1 : co0;

  always_comb begin
    AST_COUT_ORDER: assert (!co0 || co1)
      else $error("carry-out with carry 0 but not with carry 1"); // R3
    AST_CAND_STEP: assert (s1 == s0 + W'(1))
      else $error("candidate sums do not differ by one"); // R2
    AST_CAND_WRAP: assert ((co0 == co1) || (s1 == '0))
      else $error("carry-outs differ without wrap to zero"); // R2
  end

endmodule

// File: rtl/hca_adder64.sv
`timescale 1ns/1ps
module hca_adder64 #(
  parameter int GROUP_W  = 8,
  parameter int N_GROUPS = 8
) (
  input  logic [GROUP_W*N_GROUPS-1:0] a_i,
  input  logic [GROUP_W*N_GROUPS-1:0] b_i,
  input  logic                        carry_i,
  output logic [GROUP_W*N_GROUPS-1:0] sum_o,
  output logic                        carry_o
);

  localparam int WIDTH = GROUP_W * N_GROUPS;
  localparam int SPAN  = GROUP_W * (N_GROUPS - 1);

  logic [WIDTH-1:0]    p, g;
  logic [N_GROUPS-1:0] gc;
  logic [N_GROUPS-1:0] grp_co;

  hca_pg_gen #(.W(WIDTH)) u_pg (
    .a_i (a_i),
    .b_i (b_i),
    .p_o (p),
    .g_o (g)
  );

  hca_carry_tree #(.GROUP_W(GROUP_W), .N_GROUPS(N_GROUPS)) u_tree (
    .p_i     (p[SPAN-1:0]),
    .g_i     (g[SPAN-1:0]),
    .carry_i (carry_i),
    .gc_o    (gc)
  );

  for (genvar k = 0; k < N_GROUPS; k++) begin : g_slice
    hca_group_sum #(.W(GROUP_W)) u_grp (
      .p_i    (p[GROUP_W*k +: GROUP_W]),
      .g_i    (g[GROUP_W*k +: GROUP_W]),
      .sel_i  (gc[k]),
      .sum_o  (sum_o[GROUP_W*k +: GROUP_W]),
      .cout_o (grp_co[k])
    );
  end

  assign carry_o = grp_co[N_GROUPS-1];

  // local slice ripple and lookahead tree must agree at every boundary
  for (genvar k = 0; k < N_GROUPS-1; k++) begin : g_agree
    always_comb begin
      AST_BOUNDARY_AGREE: assert (grp_co[k] == gc[k+1])
        else $error("slice carry-out disagrees with tree carry"); // R4
    end
  end

  always_comb begin
    AST_SUM_EXACT: assert ({carry_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, carry_i}))
      else $error("sum differs from arithmetic add"); // R1
  end

endmodule

// File: tb/test_hca_adder64.sv
`timescale 1ns/1ps
module test_hca_adder64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] a, b, s;
  logic        ci, co;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  hca_adder64 i_hca_adder64 (
    .a_i     (a),
    .b_i     (b),
    .carry_i (ci),
    .sum_o   (s),
    .carry_o (co)
  );

  task automatic check(input string tag, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [64:0] ref_add(input logic [63:0] x, input logic [63:0] y, input logic c);
    return {1'b0, x} + {1'b0, y} + {64'd0, c};
  endfunction

  // drive away from the edge, sample 1 ns later
  task automatic apply(input logic [63:0] x, input logic [63:0] y, input logic c);
    @(negedge clk);
    a = x; b = y; ci = c;
    #1;
  endtask

  task automatic t_idle;
    apply(64'd0, 64'd0, 1'b0);
    check("R1 zero operands", {co, s}, 65'd0);
    apply(64'd0, 64'd0, 1'b1);
    check("R5 carry only", {co, s}, 65'd1);
  endtask

  task automatic t_inverse;
    logic [63:0] x;
    for (int i = 0; i < 4; i++) begin
      x = {$urandom, $urandom};
      apply(x, ~x, 1'b1);
      check("R5 inverse with carry", {co, s}, {1'b1, 64'd0});
      apply(x, ~x, 1'b0);
      check("R5 inverse without carry", {co, s}, {1'b0, {64{1'b1}}});
    end
  endtask

  task automatic t_all_ones;
    apply({64{1'b1}}, {64{1'b1}}, 1'b0);
    check("R6 all ones c0", {co, s}, {1'b1, {63{1'b1}}, 1'b0});
    apply({64{1'b1}}, {64{1'b1}}, 1'b1);
    check("R6 all ones c1", {co, s}, {1'b1, {64{1'b1}}});
  endtask

  task automatic t_boundaries;
    logic [63:0] low;
    for (int k = 1; k < 8; k++) begin
      low = (64'd1 << (8*k)) - 64'd1;
      apply(low, 64'd1, 1'b0);
      check($sformatf("R4 boundary %0d via b", k), {co, s}, {1'b0, 64'd1 << (8*k)});
      apply(low, 64'd0, 1'b1);
      check($sformatf("R4 boundary %0d via carry_i", k), {co, s}, {1'b0, 64'd1 << (8*k)});
    end
  endtask

  task automatic t_generate;
    logic [63:0] x;
    logic [64:0] exp;
    for (int k = 0; k < 8; k++) begin
      x = 64'h80 << (8*k);
      exp = 65'd1 << (8*k + 8);
      apply(x, x, 1'b0);
      check($sformatf("R3 slice %0d generates", k), {co, s}, exp);
      apply(x, x, 1'b1);
      check($sformatf("R3 slice %0d generates with carry", k), {co, s}, exp | 65'd1);
    end
  endtask

  task automatic t_wrap;
    apply(64'h0000_0000_0000_00FF, 64'd0, 1'b1);
    check("R2 slice wraps to zero", {co, s}, 65'h100);
    apply(64'h0000_FF00_0000_0000, 64'h0000_00FF_FFFF_FFFF, 1'b1);
    check("R2 middle slice wraps", {co, s}, 65'h0001_0000_0000_0000);
  endtask

  task automatic t_top;
    apply(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    check("R8 carry generated at bit 63", {co, s}, {1'b1, 64'd0});
    apply({64{1'b1}}, 64'd1, 1'b0);
    check("R8 carry through top slice", {co, s}, {1'b1, 64'd0});
    apply(64'hFF00_0000_0000_0000, 64'h0100_0000_0000_0000, 1'b0);
    check("R8 carry from top slice alone", {co, s}, {1'b1, 64'd0});
  endtask

  task automatic t_comb;
    logic [63:0] x1, y1, x2, y2;
    x1 = {$urandom, $urandom}; y1 = {$urandom, $urandom};
    x2 = {$urandom, $urandom}; y2 = {$urandom, $urandom};
    @(negedge clk);
    a = x1; b = y1; ci = 1'b0;
    #0.5;
    check("R7 first set in period", {co, s}, ref_add(x1, y1, 1'b0));
    a = x2; b = y2; ci = 1'b1;
    #0.5;
    check("R7 second set same period", {co, s}, ref_add(x2, y2, 1'b1));
  endtask

  task automatic t_random;
    logic [63:0] x, y;
    logic        c;
    for (int i = 0; i < 300; i++) begin
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      c = 1'($urandom);
      apply(x, y, c);
      check("R1 random operands", {co, s}, ref_add(x, y, c));
    end
  endtask

  initial begin
    a = '0; b = '0; ci = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_idle;
    t_inverse;
    t_all_ones;
    t_boundaries;
    t_generate;
    t_wrap;
    t_top;
    t_comb;
    t_random;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule